// File: doc/BRIEF.md
# RV64 Integer Execute Stage

This block performs the integer arithmetic, logic, compare and shift operations of a 64-bit RISC-V style core. Each operation arrives as one stream beat carrying the major opcode, the 3-bit and 7-bit function fields, two 64-bit register operands and an already sign-extended immediate. The block decodes the fields, selects either the second register or the immediate as the second operand, and computes the result. It returns the result, with a flag that marks an unsupported encoding, one cycle later on an output stream.

Two datapaths sit side by side. The full-width path works on all 64 bits and takes a 6-bit shift amount. The word path works on the low 32 bits, takes a 5-bit shift amount and sign-extends its 32-bit result from bit 31 to 64 bits. An unsupported encoding produces a zero result with the flag set, so a later stage can raise an exception without an extra decode.

The input side uses valid/ready. A beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. An output beat stays on the port, unchanged, until `out_ready` takes it. The block holds one beat at most.

Top module: `exec_unit_rv64`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `out_valid` is 0 and `in_ready` is 1.
- R2: A beat accepted at a clock edge appears on `out_valid`/`out_result`/`out_illegal` immediately after that edge. While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the outputs hold their values. When the output drains, a new beat can be accepted at the same edge.
- R3: Opcode 0x13 selects the register-immediate form, with the immediate as second operand. funct3 selects the operation: 0 add, 1 shift left, 2 signed less-than, 3 unsigned less-than, 4 xor, 5 shift right, 6 or, 7 and. For the unsigned compare, the sign-extended immediate is treated as an unsigned 64-bit value.
- R4: Opcode 0x33 selects the register-register form with the same funct3 mapping. funct7 0x00 selects add, and logical shift right for funct3 5. funct7 0x20 selects subtract for funct3 0 and arithmetic shift right for funct3 5.
- R5: The 64-bit shifts use a 6-bit amount. In register form this is `in_rs2[5:0]`. In immediate form it is `in_imm[5:0]`, and higher bits of `in_rs2` have no effect.
- R6: Opcodes 0x1b (immediate: add, sll, srl, sra) and 0x3b (register: add, sub, sll, srl, sra) operate on bits 31:0 of the operands with a 5-bit shift amount. Every such result, including a logical right shift, is sign-extended from bit 31.
- R7: Both less-than operations return exactly 1 or 0 in the full 64-bit width.
- R8: Any other opcode, or any funct3/funct7 combination not listed, gives `out_illegal` = 1 and `out_result` = 0. In immediate shifts, funct7 bits 6:1 must be 000000 (left or logical right) or 010000 (arithmetic right). For 0x1b shifts, funct7 must be 0x00 or 0x20.
- R9: In the immediate form of the non-shift operations (0x13 funct3 0,2,3,4,6,7 and 0x1b funct3 0), funct7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_opcode | input | 7 | Major opcode |
| in_funct3 | input | 3 | Operation select |
| in_funct7 | input | 7 | Variant select |
| in_rs1 | input | 64 | First operand |
| in_rs2 | input | 64 | Second register operand |
| in_imm | input | 64 | Sign-extended immediate |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Operation result |
| out_illegal | output | 1 | Encoding not supported |

## Verification
A decode error appears at the ports one cycle after the beat is accepted. It shows up as a wrong result value, as a flag set on a legal encoding, or as a non-zero result next to a set flag. A fault in the word path shows as upper bits that do not copy bit 31. A shift-mask fault shows when high operand bits above the amount field change the result. A fault in the holding register shows during back-pressure as an output that changes, or a beat that is lost, before `out_ready` rises.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam logic [6:0] OPC_IMM    = 7'h13;
  localparam logic [6:0] OPC_REG    = 7'h33;
  localparam logic [6:0] OPC_IMM_W  = 7'h1b;
  localparam logic [6:0] OPC_REG_W  = 7'h3b;
  localparam logic [6:0] F7_BASE    = 7'h00;
  localparam logic [6:0] F7_ALT     = 7'h20;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU,
    OP_XOR, OP_SRL, OP_SRA, OP_OR, OP_AND
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    word;
    logic    use_imm;
    logic    illegal;
  } dec_t;
endpackage

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output dec_t       dec
);
  logic f7_base, f7_alt, f7i_base, f7i_alt;

  always_comb begin
    f7_base  = (funct7 == F7_BASE);
    f7_alt   = (funct7 == F7_ALT);
    // 64-bit immediate shifts: funct7 bit 0 belongs to the shift amount
    f7i_base = (funct7[6:1] == 6'b000000);
    f7i_alt  = (funct7[6:1] == 6'b010000);

    dec.op      = OP_ADD;
    dec.word    = 1'b0;
    dec.use_imm = 1'b0;
    dec.illegal = 1'b0;

    unique case (opcode)
      OPC_IMM, OPC_REG: begin
        dec.use_imm = (opcode == OPC_IMM);
        unique case (funct3)
          3'd0: dec.op = (!dec.use_imm && f7_alt) ? OP_SUB : OP_ADD;
          3'd1: dec.op = OP_SLL;
          3'd2: dec.op = OP_SLT;
          3'd3: dec.op = OP_SLTU;
          3'd4: dec.op = OP_XOR;
          3'd5: dec.op = (dec.use_imm ? f7i_alt : f7_alt) ? OP_SRA : OP_SRL;
          3'd6: dec.op = OP_OR;
          default: dec.op = OP_AND;
        endcase
        if (dec.use_imm) begin
          if (funct3 == 3'd1) dec.illegal = !f7i_base;
          if (funct3 == 3'd5) dec.illegal = !(f7i_base || f7i_alt);
        end else begin
          if (funct3 == 3'd0 || funct3 == 3'd5) dec.illegal = !(f7_base || f7_alt);
          else                                   dec.illegal = !f7_base;
        end
      end
      OPC_IMM_W, OPC_REG_W: begin
        dec.word    = 1'b1;
        dec.use_imm = (opcode == OPC_IMM_W);
        unique case (funct3)
          3'd0: begin
            dec.op      = (!dec.use_imm && f7_alt) ? OP_SUB : OP_ADD;
            dec.illegal = !dec.use_imm && !(f7_base || f7_alt);
          end
          3'd1: begin
            dec.op      = OP_SLL;
            dec.illegal = !f7_base;
          end
          3'd5: begin
            dec.op      = f7_alt ? OP_SRA : OP_SRL;
            dec.illegal = !(f7_base || f7_alt);
          end
          default: dec.illegal = 1'b1;
        endcase
      end
      default: dec.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/exec_shifter.sv
module exec_shifter #(
  parameter int W = 64,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] amt,
  input  logic          right,
  input  logic          arith,
  output logic [W-1:0]  y
);
  always_comb begin
    if (!right)     y = a << amt;
    else if (arith) y = W'($signed(a) >>> amt);
    else            y = a >> amt;
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  input  logic            word,
  output logic [XLEN-1:0] y
);
  localparam int XSW = $clog2(XLEN);
  localparam int WSW = $clog2(WLEN);

  logic [XLEN-1:0] full_sh, full_y;
  logic [WLEN-1:0] word_sh, word_y;
  logic            right, arith;

  assign right = (op == OP_SRL) || (op == OP_SRA);
  assign arith = (op == OP_SRA);

  // two shifter widths, one per datapath
  for (genvar g = 0; g < 2; g++) begin : g_sh
    if (g == 0) begin : g_full
      exec_shifter #(.W(XLEN)) u_sh (
        .a(a), .amt(b[XSW-1:0]), .right(right), .arith(arith), .y(full_sh));
    end else begin : g_word
      exec_shifter #(.W(WLEN)) u_sh (
        .a(a[WLEN-1:0]), .amt(b[WSW-1:0]), .right(right), .arith(arith), .y(word_sh));
    end
  end

  always_comb begin
    unique case (op)
      OP_ADD:  full_y = a + b;
      OP_SUB:  full_y = a - b;
      OP_SLT:  full_y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      OP_SLTU: full_y = {{(XLEN-1){1'b0}}, a < b};
      OP_XOR:  full_y = a ^ b;
      OP_OR:   full_y = a | b;
      OP_AND:  full_y = a & b;
      default: full_y = full_sh;
    endcase
    unique case (op)
      OP_ADD:  word_y = a[WLEN-1:0] + b[WLEN-1:0];
      OP_SUB:  word_y = a[WLEN-1:0] - b[WLEN-1:0];
      default: word_y = word_sh;
    endcase
    y = word ? {{(XLEN-WLEN){word_y[WLEN-1]}}, word_y} : full_y;
  end
endmodule

// File: rtl/exec_unit_rv64.sv
module exec_unit_rv64
  import exec_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [6:0]      in_opcode,
  input  logic [2:0]      in_funct3,
  input  logic [6:0]      in_funct7,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  input  logic [XLEN-1:0] in_imm,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);
  dec_t            dec;
  logic [XLEN-1:0] opb, alu_y;
  logic            take;

  exec_decode u_dec (
    .opcode(in_opcode), .funct3(in_funct3), .funct7(in_funct7), .dec(dec));

  assign opb = dec.use_imm ? in_imm : in_rs2;

  exec_alu #(.XLEN(XLEN), .WLEN(WLEN)) u_alu (
    .a(in_rs1), .b(opb), .op(dec.op), .word(dec.word), .y(alu_y));

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_result  <= dec.illegal ? '0 : alu_y;
        out_illegal <= dec.illegal;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exec_unit_rv64_chk.sv
module exec_unit_rv64_chk #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [6:0]      in_opcode,
  input logic [2:0]      in_funct3,
  input logic [6:0]      in_funct7,
  input logic [XLEN-1:0] in_rs1,
  input logic [XLEN-1:0] in_rs2,
  input logic [XLEN-1:0] in_imm,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic            out_illegal
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_accept_shows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  assert_word_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_opcode == 7'h1b || in_opcode == 7'h3b))
      |=> (out_result[XLEN-1:WLEN] == {(XLEN-WLEN){out_result[WLEN-1]}}));

  assert_slt_bool_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_opcode == 7'h13 || in_opcode == 7'h33) && (in_funct3 == 3'd2 || in_funct3 == 3'd3))
      |=> (out_result[XLEN-1:1] == '0));

  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0));
endmodule

bind exec_unit_rv64 exec_unit_rv64_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (.*);

// File: tb/sim_exec_unit_rv64.sv
module sim_exec_unit_rv64;
  localparam int PERIOD = 10;
  localparam int NV = 34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid, out_illegal;
  logic [6:0]  in_opcode = '0, in_funct7 = '0;
  logic [2:0]  in_funct3 = '0;
  logic [63:0] in_rs1 = '0, in_rs2 = '0, in_imm = '0, out_result;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  exec_unit_rv64 u0 (.*);

  // vector: {opcode, funct3, funct7, rs1, rs2, imm}
  localparam logic [208:0] VEC [NV] = '{
    {7'h13,3'd0,7'h00,64'd5,64'd0,-64'sd3},                       // R3 addi
    {7'h13,3'd0,7'h7f,64'd5,64'd9,64'd7},                          // R9 addi, funct7 ignored
    {7'h13,3'd2,7'h00,64'd5,64'd0,-64'sd1},                        // R3 R7 slti
    {7'h13,3'd3,7'h00,64'd5,64'd0,-64'sd1},                        // R3 R7 sltiu unsigned imm
    {7'h13,3'd4,7'h55,64'hf0f0,64'd0,64'hffffffffffffff0f},        // R3 R9 xori
    {7'h13,3'd6,7'h00,64'h100,64'd0,64'h0ff},                      // R3 ori
    {7'h13,3'd7,7'h00,64'hffff,64'd0,64'h0f0},                     // R3 andi
    {7'h13,3'd1,7'h01,64'd1,64'hffff,64'h021},                     // R5 slli by 33
    {7'h13,3'd5,7'h00,64'h8000000000000000,64'd0,64'h03f},         // R5 srli 63
    {7'h13,3'd5,7'h20,64'h8000000000000000,64'd0,64'h404},         // R5 srai 4
    {7'h13,3'd1,7'h02,64'd1,64'd0,64'h040},                        // R8 slli bad funct7
    {7'h13,3'd5,7'h30,64'd1,64'd0,64'h600},                        // R8 srai bad funct7
    {7'h33,3'd0,7'h00,64'hffffffffffffffff,64'd1,64'd0},           // R4 add wrap
    {7'h33,3'd0,7'h20,64'd3,64'd5,64'd0},                          // R4 sub
    {7'h33,3'd1,7'h00,64'd3,64'hffffffffffffffc1,64'd0},           // R5 sll mask
    {7'h33,3'd5,7'h00,64'h8000000000000000,64'h7f,64'd0},          // R5 srl mask
    {7'h33,3'd5,7'h20,64'h8000000000000000,64'h3c,64'd0},          // R4 sra
    {7'h33,3'd2,7'h00,-64'sd2,64'd1,64'd0},                        // R7 slt neg
    {7'h33,3'd3,7'h00,-64'sd2,64'd1,64'd0},                        // R7 sltu
    {7'h33,3'd4,7'h00,64'hff00,64'h0ff0,64'd0},                    // R4 xor
    {7'h33,3'd6,7'h00,64'hff00,64'h0ff0,64'd0},                    // R4 or
    {7'h33,3'd7,7'h00,64'hff00,64'h0ff0,64'd0},                    // R4 and
    {7'h33,3'd0,7'h01,64'd1,64'd1,64'd0},                          // R8 add bad funct7
    {7'h33,3'd1,7'h20,64'd1,64'd1,64'd0},                          // R8 sll alt funct7
    {7'h3b,3'd0,7'h00,64'h7fffffff,64'd1,64'd0},                   // R6 addw overflow
    {7'h3b,3'd0,7'h20,64'hffffffff00000000,64'd1,64'd0},           // R6 subw
    {7'h3b,3'd1,7'h00,64'h1,64'h3f,64'd0},                         // R6 sllw 5-bit mask
    {7'h3b,3'd5,7'h00,64'h1234567880000000,64'h20,64'd0},          // R6 srlw by 0, sign-ext
    {7'h3b,3'd5,7'h20,64'h80000000,64'h4,64'd0},                   // R6 sraw
    {7'h1b,3'd0,7'h7f,64'hffffffff7fffffff,64'd0,64'd1},           // R6 R9 addiw
    {7'h1b,3'd5,7'h00,64'h80000000,64'd0,64'h001},                 // R6 srliw
    {7'h1b,3'd2,7'h00,64'd1,64'd0,64'd1},                          // R8 word slt
    {7'h3b,3'd1,7'h20,64'd1,64'd1,64'd0},                          // R8 sllw alt funct7
    {7'h03,3'd0,7'h00,64'd1,64'd1,64'd1}                           // R8 load opcode
  };

  function automatic logic [64:0] ref_model(input logic [6:0] opc, input logic [2:0] f3,
      input logic [6:0] f7, input logic [63:0] x, input logic [63:0] r2, input logic [63:0] im);
    logic [63:0] b;
    logic [31:0] w;
    logic ill;
    logic [63:0] res;
    ill = 1'b0; res = '0; w = '0;
    b = (opc == 7'h13 || opc == 7'h1b) ? im : r2;
    if (opc == 7'h13 || opc == 7'h33) begin
      case (f3)
        3'd0: if (opc == 7'h33 && f7 == 7'h20) res = x - b;
              else begin res = x + b; ill = (opc == 7'h33 && f7 != 0); end
        3'd1: begin res = x << b[5:0]; ill = (opc == 7'h13) ? (f7[6:1] != 0) : (f7 != 0); end
        3'd2: begin res = ($signed(x) < $signed(b)) ? 64'd1 : 64'd0; ill = (opc == 7'h33 && f7 != 0); end
        3'd3: begin res = (x < b) ? 64'd1 : 64'd0; ill = (opc == 7'h33 && f7 != 0); end
        3'd4: begin res = x ^ b; ill = (opc == 7'h33 && f7 != 0); end
        3'd5: begin
          logic alt;
          alt = (opc == 7'h13) ? (f7[6:1] == 6'b010000) : (f7 == 7'h20);
          ill = (opc == 7'h13) ? !(f7[6:1] == 0 || alt) : !(f7 == 0 || alt);
          res = alt ? 64'($signed(x) >>> b[5:0]) : x >> b[5:0];
        end
        3'd6: begin res = x | b; ill = (opc == 7'h33 && f7 != 0); end
        default: begin res = x & b; ill = (opc == 7'h33 && f7 != 0); end
      endcase
    end else if (opc == 7'h1b || opc == 7'h3b) begin
      case (f3)
        3'd0: if (opc == 7'h3b && f7 == 7'h20) w = x[31:0] - b[31:0];
              else begin w = x[31:0] + b[31:0]; ill = (opc == 7'h3b && f7 != 0); end
        3'd1: begin w = x[31:0] << b[4:0]; ill = (f7 != 0); end
        3'd5: begin
          w = (f7 == 7'h20) ? 32'($signed(x[31:0]) >>> b[4:0]) : x[31:0] >> b[4:0];
          ill = !(f7 == 0 || f7 == 7'h20);
        end
        default: ill = 1'b1;
      endcase
      res = {{32{w[31]}}, w};
    end else ill = 1'b1;
    if (ill) res = '0;
    return {ill, res};
  endfunction

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got ill=%0b res=%h, expected ill=%0b res=%h",
               req, act[64], act[63:0], exp[64], exp[63:0]);
    end
  endtask

  task automatic drive(input logic [208:0] v);
    {in_opcode, in_funct3, in_funct7, in_rs1, in_rs2, in_imm} = v;
    in_valid = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [64:0] exp_a;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid/in_ready", {63'd0, out_valid, in_ready}, 65'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {63'd0, out_valid, in_ready}, 65'd1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R2 vector %0d valid", i), {64'd0, out_valid}, 65'd1);
      check($sformatf("R3-R9 vector %0d", i), {out_illegal, out_result},
            ref_model(VEC[i][208:202], VEC[i][201:199], VEC[i][198:192],
                      VEC[i][191:128], VEC[i][127:64], VEC[i][63:0]));
    end

    // directed: hand-computed values
    drive({7'h3b,3'd5,7'h00,64'h0000000080000000,64'h0,64'd0});
    @(negedge clk); in_valid = 1'b0;
    check("R6 srlw zero shift sign-extends", {out_illegal, out_result}, {1'b0, 64'hffffffff80000000});
    drive({7'h13,3'd3,7'h00,64'd5,64'd0,64'hffffffffffffffff});
    @(negedge clk); in_valid = 1'b0;
    check("R3 sltiu -1 as unsigned max", {out_illegal, out_result}, {1'b0, 64'd1});
    drive({7'h33,3'd2,7'h00,64'hffffffffffffffff,64'd0,64'd0});
    @(negedge clk); in_valid = 1'b0;
    check("R7 slt one", {out_illegal, out_result}, {1'b0, 64'd1});
    drive({7'h33,3'd1,7'h00,64'd1,64'hffffffffffffff40,64'd0});
    @(negedge clk); in_valid = 1'b0;
    check("R5 sll high rs2 bits ignored", {out_illegal, out_result}, {1'b0, 64'd1});
    drive({7'h33,3'd5,7'h40,64'd8,64'd1,64'd0});
    @(negedge clk); in_valid = 1'b0;
    check("R8 illegal zero", {out_illegal, out_result}, {1'b1, 64'd0});
    @(negedge clk);
    check("R2 drains", {64'd0, out_valid}, 65'd0);

    // back-pressure
    out_ready = 1'b0;
    drive({7'h33,3'd0,7'h00,64'd10,64'd20,64'd0});
    exp_a = {1'b0, 64'd30};
    @(negedge clk);
    check("R2 stall in_ready low", {63'd0, out_valid, in_ready}, 65'd2);
    drive({7'h33,3'd0,7'h20,64'd10,64'd3,64'd0});
    @(negedge clk);
    check("R2 held under stall", {out_illegal, out_result}, exp_a);
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check("R2 drain and accept same edge", {out_illegal, out_result}, {1'b0, 64'd7});
    check("R2 second beat valid", {64'd0, out_valid}, 65'd1);

    // reset mid-stream
    drive({7'h33,3'd0,7'h00,64'd1,64'd1,64'd0});
    rst_n = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    check("R1 reset clears output", {63'd0, out_valid, in_ready}, 65'd1);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule